// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration core of an eight-line interrupt controller. It holds the in-service vector, a movable priority base and the rotate-on-auto-acknowledge flag. From the pending request vector and the mask vector it chooses one line to present to the processor, and it presents that line only when its level is strictly above every level already in service. Priority rotates: the line at the base position is the most urgent, and urgency falls as the index counts up from the base and wraps around.

An acknowledge pulse accepts the presented line. Normally the line is entered into the in-service vector. When auto end-of-interrupt is enabled, nothing is entered, and the base may move past the acknowledged line. Already-decoded commands retire in-service lines, either the most urgent one or a named one, and can move the base. A primary/secondary input together with a nesting enable lets the primary instance disregard its cascade line when it measures the current service level.

Top module: `rot_prio_resolver`

## Requirements
- R1: Line i has rank ((i - base) mod 8), and rank 0 is the most urgent. Of the lines that are pending and unmasked, the one with the lowest rank is presented on `irq_line` with `irq_valid` high. After reset the base is 0, so line 0 is the most urgent.
- R2: `irq_valid` is high only for a line whose `req_vec` bit is 1 and whose `mask_vec` bit is 0. It is low when no such line exists.
- R3: The candidate is presented only when its rank is strictly lower than the lowest rank in the in-service vector. An empty in-service vector counts as rank 8. A candidate of equal or worse rank keeps `irq_valid` low.
- R4: When `sfnm_en` is 1 and `is_primary` is 1, in-service bit 2 is left out of the service-level comparison. When either input is 0, bit 2 takes part.
- R5: `ack` high while `irq_valid` is high and `auto_eoi_en` is 0 sets the in-service bit of the presented line at the next clock edge. `ack` while `irq_valid` is low changes nothing.
- R6: `ack` while `irq_valid` is high and `auto_eoi_en` is 1 sets no in-service bit. If the rotate flag `rot_aeoi` is 1, the base becomes (line + 1) mod 8.
- R7: `cmd_code` 1 clears the in-service bit of lowest rank. `cmd_code` 5 does the same and also sets the base to (cleared line + 1) mod 8. Both codes change nothing when the in-service vector is empty.
- R8: `cmd_code` 3 clears the in-service bit selected by `cmd_line`. `cmd_code` 7 does the same and also sets the base to (`cmd_line` + 1) mod 8.
- R9: `cmd_code` 6 sets the base to (`cmd_line` + 1) mod 8. `cmd_code` 4 sets `rot_aeoi`, `cmd_code` 0 clears it, and `cmd_code` 2 has no effect. A command applies only when `cmd_valid` is high, at the next clock edge.
- R10: Reset (active-low `rst_n`) clears the in-service vector, the base and `rot_aeoi` to 0.
- R11: When an acknowledge and a command fall in the same cycle, both take effect at the next edge. The acknowledge's in-service set is applied after the command's clear. A base written by the command replaces any rotation caused by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | 8 | Pending request vector |
| mask_vec | input | 8 | Mask vector, 1 blocks a line |
| is_primary | input | 1 | Instance is the primary in a cascade |
| sfnm_en | input | 1 | Nested mode that disregards the cascade line |
| auto_eoi_en | input | 1 | Auto end-of-interrupt on acknowledge |
| ack | input | 1 | Acknowledge of the presented line |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (0..7, see R7 to R9) |
| cmd_line | input | 3 | Line operand of a command |
| irq_valid | output | 1 | A line is presented |
| irq_line | output | 3 | Index of the presented line |
| isr_vec | output | 8 | In-service vector |
| base_idx | output | 3 | Current priority base |
| rot_aeoi | output | 1 | Rotate-on-auto-acknowledge flag |

## Verification
The acknowledge path and the command path both write the in-service vector and the base in the same edge. The bench drives them together on purpose in two cases. In the first, a specific clear of line 2 and an acknowledge of line 1 arrive together, and the bench expects only bit 1 to remain set. In the second, an auto-acknowledge with rotation enabled arrives in the same cycle as a set-base command, and the bench expects the base the command names rather than the one the rotation would give. The result of each case is read from the outputs after the edge.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
   typedef enum logic [2:0] {
      OP_ROT_CLR    = 3'd0,
      OP_EOI_TOP    = 3'd1,
      OP_IDLE       = 3'd2,
      OP_EOI_LINE   = 3'd3,
      OP_ROT_SET    = 3'd4,
      OP_EOI_TOP_RB = 3'd5,
      OP_BASE_LOAD  = 3'd6,
      OP_EOI_LINE_RB= 3'd7
   } op_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [IW-1:0] base,
   output logic [IW:0]   rank,
   output logic [IW-1:0] line
);
   logic [IW-1:0] idx;

   always_comb begin
      rank = (IW+1)'(N);
      line = '0;
      idx  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         idx = IW'(base + IW'(k));
         if (vec[idx]) begin
            rank = (IW+1)'(k);
            line = idx;
         end
      end
   end
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
   import prio_res_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_fire,
   input  logic [IW-1:0] ack_line,
   input  logic          auto_eoi_en,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_code,
   input  logic [IW-1:0] cmd_line,
   input  logic          top_hit,
   input  logic [IW-1:0] top_line,
   output logic [N-1:0]  isr_q,
   output logic [IW-1:0] base_q,
   output logic          rot_q
);
   logic [N-1:0]  clr_m, set_m;
   logic [IW-1:0] base_n;
   logic          rot_n;
   op_e           op;

   assign op = op_e'(cmd_code);

   always_comb begin
      clr_m  = '0;
      set_m  = '0;
      base_n = base_q;
      rot_n  = rot_q;
      if (ack_fire) begin
         if (auto_eoi_en) begin
            if (rot_q) base_n = IW'(ack_line + 1'b1);
         end else begin
            set_m[ack_line] = 1'b1;
         end
      end
      if (cmd_valid) begin
         unique case (op)
            OP_ROT_CLR:  rot_n = 1'b0;
            OP_ROT_SET:  rot_n = 1'b1;
            OP_EOI_TOP:  if (top_hit) clr_m[top_line] = 1'b1;
            OP_EOI_TOP_RB: if (top_hit) begin
               clr_m[top_line] = 1'b1;
               base_n = IW'(top_line + 1'b1);
            end
            OP_EOI_LINE: clr_m[cmd_line] = 1'b1;
            OP_EOI_LINE_RB: begin
               clr_m[cmd_line] = 1'b1;
               base_n = IW'(cmd_line + 1'b1);
            end
            OP_BASE_LOAD: base_n = IW'(cmd_line + 1'b1);
            OP_IDLE: ;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q  <= '0;
         base_q <= '0;
         rot_q  <= 1'b0;
      end else begin
         isr_q  <= (isr_q & ~clr_m) | set_m;
         base_q <= base_n;
         rot_q  <= rot_n;
      end
   end

   AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_code == 3'd3 || cmd_code == 3'd7) &&
       !(ack_fire && !auto_eoi_en && ack_line == cmd_line))
      |=> !isr_q[$past(cmd_line)]); // R8

   AST_ROT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 3'd4) |=> rot_q); // R9
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
   parameter int N           = 8,
   parameter int CASCADE_IDX = 2,
   parameter bit HAS_NESTED  = 1'b1,
   localparam int IW         = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_vec,
   input  logic [N-1:0]  mask_vec,
   input  logic          is_primary,
   input  logic          sfnm_en,
   input  logic          auto_eoi_en,
   input  logic          ack,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_code,
   input  logic [IW-1:0] cmd_line,
   output logic          irq_valid,
   output logic [IW-1:0] irq_line,
   output logic [N-1:0]  isr_vec,
   output logic [IW-1:0] base_idx,
   output logic          rot_aeoi
);
   if (N < 2 || (1 << IW) != N) begin : g_bad_n
      $error("N must be a power of two of at least 2");
   end
   if (CASCADE_IDX < 0 || CASCADE_IDX >= N) begin : g_bad_casc
      $error("CASCADE_IDX out of range");
   end

   logic [N-1:0]  live_req, cmp_isr;
   logic [IW:0]   req_rank, cur_rank, top_rank;
   logic [IW-1:0] req_line, cur_line, top_line;

   assign live_req = req_vec & ~mask_vec;

   if (HAS_NESTED) begin : g_nested
      logic [N-1:0] casc_bit;
      assign casc_bit = N'(1) << CASCADE_IDX;
      assign cmp_isr  = (sfnm_en && is_primary) ? (isr_vec & ~casc_bit) : isr_vec;
   end else begin : g_flat
      logic unused_nest;
      assign unused_nest = sfnm_en ^ is_primary;
      assign cmp_isr     = isr_vec;
   end

   prio_pick #(.N(N)) u_req_pick (
      .vec(live_req), .base(base_idx), .rank(req_rank), .line(req_line));
   prio_pick #(.N(N)) u_cur_pick (
      .vec(cmp_isr),  .base(base_idx), .rank(cur_rank), .line(cur_line));
   prio_pick #(.N(N)) u_top_pick (
      .vec(isr_vec),  .base(base_idx), .rank(top_rank), .line(top_line));

   assign irq_valid = (req_rank < cur_rank);
   assign irq_line  = req_line;

   isr_ctrl #(.N(N)) u_isr (
      .clk(clk), .rst_n(rst_n),
      .ack_fire(ack && irq_valid), .ack_line(irq_line),
      .auto_eoi_en(auto_eoi_en),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_line(cmd_line),
      .top_hit(top_rank != (IW+1)'(N)), .top_line(top_line),
      .isr_q(isr_vec), .base_q(base_idx), .rot_q(rot_aeoi));

   AST_VALID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (req_vec[irq_line] && !mask_vec[irq_line])); // R2

   AST_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !(sfnm_en && is_primary && irq_line == IW'(CASCADE_IDX)))
      |-> !isr_vec[irq_line]); // R3

   AST_CUR_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_rank != (IW+1)'(N)) |-> isr_vec[cur_line]); // R3

   AST_NEST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_NESTED && sfnm_en && is_primary && live_req != '0 &&
       (isr_vec & ~(N'(1) << CASCADE_IDX)) == '0) |-> irq_valid); // R4

   AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_valid && !auto_eoi_en) |=> isr_vec[$past(irq_line)]); // R5

   AST_AEOI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_valid && auto_eoi_en && !cmd_valid) |=> $stable(isr_vec)); // R6

   AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_code == 3'd1 || cmd_code == 3'd5) && isr_vec == '0 && !ack)
      |=> (isr_vec == '0 && $stable(base_idx))); // R7

   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 3'd6)
      |=> base_idx == IW'($past(cmd_line) + 1'b1)); // R9
endmodule

// File: tb/tb_rot_prio_resolver.sv
module tb_rot_prio_resolver;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_vec, mask_vec;
   logic       is_primary, sfnm_en, auto_eoi_en, ack, cmd_valid;
   logic [2:0] cmd_code, cmd_line;
   logic       irq_valid, rot_aeoi;
   logic [2:0] irq_line, base_idx;
   logic [7:0] isr_vec;

   rot_prio_resolver dut (
      .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
      .is_primary(is_primary), .sfnm_en(sfnm_en), .auto_eoi_en(auto_eoi_en),
      .ack(ack), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_line(cmd_line),
      .irq_valid(irq_valid), .irq_line(irq_line), .isr_vec(isr_vec),
      .base_idx(base_idx), .rot_aeoi(rot_aeoi));

   always #5 clk = ~clk;

   typedef struct {
      string      tag;
      logic       v;
      logic [2:0] ln;
      logic [7:0] isr;
      logic [2:0] base;
      logic       rot;
   } exp_t;

   exp_t sb_q[$];
   event sb_ev;
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   task automatic expect_out(string tag, logic v, logic [2:0] ln,
                             logic [7:0] isr, logic [2:0] base, logic rot);
      exp_t e;
      e.tag = tag; e.v = v; e.ln = ln; e.isr = isr; e.base = base; e.rot = rot;
      sb_q.push_back(e);
      ->sb_ev;
      #1;
   endtask

   initial begin
      forever begin
         @(sb_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (irq_valid !== e.v || (e.v && irq_line !== e.ln) ||
                isr_vec !== e.isr || base_idx !== e.base || rot_aeoi !== e.rot) begin
               n_fail++;
               $display("FAIL %s: got v=%0b line=%0d isr=%02h base=%0d rot=%0b exp v=%0b line=%0d isr=%02h base=%0d rot=%0b",
                        e.tag, irq_valid, irq_line, isr_vec, base_idx, rot_aeoi,
                        e.v, e.ln, e.isr, e.base, e.rot);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic do_cmd(logic [2:0] code, logic [2:0] ln);
      cmd_valid = 1'b1; cmd_code = code; cmd_line = ln;
      tick();
      cmd_valid = 1'b0;
   endtask

   task automatic set_req(logic [7:0] r);
      req_vec = r; #1;
   endtask

   initial begin
      rst_n = 1'b0; req_vec = '0; mask_vec = '0; is_primary = 1'b1; sfnm_en = 1'b0;
      auto_eoi_en = 1'b0; ack = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_line = '0;
      repeat (3) @(negedge clk);
      #1;
      expect_out("R10 reset state", 0, 0, 8'h00, 0, 0);
      rst_n = 1'b1; tick();
      expect_out("R10 after release", 0, 0, 8'h00, 0, 0);

      set_req(8'hA0); expect_out("R1 lines 5,7 base 0", 1, 5, 8'h00, 0, 0);
      set_req(8'h81); expect_out("R1 line 0 beats 7", 1, 0, 8'h00, 0, 0);
      mask_vec = 8'h01; #1; expect_out("R2 mask line 0", 1, 7, 8'h00, 0, 0);
      mask_vec = 8'h81; #1; expect_out("R2 all masked", 0, 0, 8'h00, 0, 0);
      mask_vec = 8'h00;

      set_req(8'h20); do_ack();
      expect_out("R5 ack line 5 / R3 equal blocked", 0, 0, 8'h20, 0, 0);
      set_req(8'h28); expect_out("R3 line 3 outranks 5", 1, 3, 8'h20, 0, 0);
      set_req(8'h80); expect_out("R3 line 7 below 5", 0, 0, 8'h20, 0, 0);

      set_req(8'h08); do_ack(); set_req(8'h00);
      expect_out("R5 nested ack line 3", 0, 0, 8'h28, 0, 0);
      do_cmd(3'd1, 3'd0); expect_out("R7 nonspecific clears 3", 0, 0, 8'h20, 0, 0);
      do_cmd(3'd3, 3'd5); expect_out("R8 specific clears 5", 0, 0, 8'h00, 0, 0);
      do_cmd(3'd1, 3'd0); expect_out("R7 empty no effect", 0, 0, 8'h00, 0, 0);

      do_cmd(3'd6, 3'd4); expect_out("R9 set base 5", 0, 0, 8'h00, 5, 0);
      set_req(8'h11); expect_out("R1 base 5 line 0 over 4", 1, 0, 8'h00, 5, 0);
      set_req(8'h30); expect_out("R1 base 5 line 5 top", 1, 5, 8'h00, 5, 0);

      set_req(8'h20); do_ack(); set_req(8'h00);
      expect_out("R5 ack line 5 base 5", 0, 0, 8'h20, 5, 0);
      do_cmd(3'd5, 3'd0); expect_out("R7 rotating EOI", 0, 0, 8'h00, 6, 0);

      set_req(8'h04); expect_out("R1 line 2 base 6", 1, 2, 8'h00, 6, 0);
      do_ack(); set_req(8'h00);
      do_cmd(3'd7, 3'd2); expect_out("R8 rotating specific", 0, 0, 8'h00, 3, 0);

      do_cmd(3'd2, 3'd5); expect_out("R9 code 2 no effect", 0, 0, 8'h00, 3, 0);
      do_cmd(3'd4, 3'd0); expect_out("R9 rot flag set", 0, 0, 8'h00, 3, 1);
      do_cmd(3'd0, 3'd0); expect_out("R9 rot flag clear", 0, 0, 8'h00, 3, 0);

      auto_eoi_en = 1'b1; set_req(8'h40); do_ack();
      expect_out("R6 auto ack no rotate", 1, 6, 8'h00, 3, 0);
      do_cmd(3'd4, 3'd0); do_ack();
      expect_out("R6 auto ack rotates", 1, 6, 8'h00, 7, 1);
      set_req(8'h00); auto_eoi_en = 1'b0;

      do_cmd(3'd6, 3'd7); set_req(8'h04); do_ack();
      expect_out("R4 setup isr bit 2", 0, 0, 8'h04, 0, 1);
      sfnm_en = 1'b1; #1; expect_out("R4 primary ignores cascade", 1, 2, 8'h04, 0, 1);
      is_primary = 1'b0; #1; expect_out("R4 secondary keeps bit 2", 0, 0, 8'h04, 0, 1);
      sfnm_en = 1'b0; is_primary = 1'b1; #1;
      expect_out("R4 mode off keeps bit 2", 0, 0, 8'h04, 0, 1);

      set_req(8'h02); expect_out("R3 line 1 over served 2", 1, 1, 8'h04, 0, 1);
      ack = 1'b1; do_cmd(3'd3, 3'd2); ack = 1'b0;
      expect_out("R11 clear 2 with ack 1", 0, 0, 8'h02, 0, 1);
      set_req(8'h00); do_cmd(3'd3, 3'd1);
      auto_eoi_en = 1'b1; set_req(8'h08);
      expect_out("R11 setup", 1, 3, 8'h00, 0, 1);
      ack = 1'b1; do_cmd(3'd6, 3'd5); ack = 1'b0;
      expect_out("R11 command base wins", 1, 3, 8'h00, 6, 1);

      auto_eoi_en = 1'b0; mask_vec = 8'h08; #1;
      do_ack(); expect_out("R5 ack while idle ignored", 0, 0, 8'h00, 6, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule